// File: doc/BRIEF.md
# Histogram-Compacting ADC Test Collector

This block sits beside an embedded analogue-to-digital converter and turns a test run of conversions into a per-code occurrence histogram kept in a local RAM. Shifting only the histogram off-chip keeps scan-path traffic small: the raw record holds thousands of conversion results, and the histogram holds one counter per output code. After a start command the collector clears every bin, then requests conversions one at a time. For each result it reads the bin that the code addresses, adds one, and writes the bin back. It stops after a fixed record length.

The finished histogram stays in RAM until a scan request arrives. The bins then leave on a single serial line at the pace of a scan-tick enable, which is independent of the conversion rate. A done flag marks the end of the unload.

The controller is one state machine with these states:
- IDLE: waiting for a start.
- CLEAR: zeroing the bins, one per clock.
- REQ: issuing the conversion request.
- WAIT: awaiting the conversion result.
- READ: fetching the addressed bin.
- WRITE: storing the incremented bin.
- HOLD: histogram complete, waiting for a scan request.
- LOAD: reading a bin for unload.
- FETCH: loading the shift register.
- SHIFT: emitting bits.
- DONE: unload finished.

Its transitions are:
- IDLE→CLEAR on start.
- CLEAR→REQ after the top code has been cleared.
- REQ→WAIT always.
- WAIT→READ on conversion done.
- READ→WRITE always.
- WRITE→REQ while samples remain, and WRITE→HOLD on the last sample.
- HOLD→CLEAR on start, and HOLD→LOAD on a new or stored scan request.
- LOAD→FETCH→SHIFT always.
- SHIFT→LOAD after the last bit of a bin below the top code, and SHIFT→DONE after the last bit of the top code.
- DONE→CLEAR on start.

Top module: `hist_collector`

## Requirements
- R1: After reset, busy, conv_start, scan_valid and unload_done are all low.
- R2: A start accepted in IDLE, HOLD or DONE raises busy. It zeroes all 2^CODE_W bins, one per clock, before the first conv_start, which appears 2^CODE_W+1 cycles after the start is sampled. Counts from an earlier run never reach the new histogram.
- R3: conv_start is a one-cycle pulse. No new pulse is issued while a conversion is outstanding or its read-modify-write is pending, so back-to-back results with the same code are all counted.
- R4: Each conv_done received while a conversion is outstanding adds exactly one to the bin whose address equals adc_code.
- R5: A run requests exactly NUM_SAMPLES conversions (2048 by default) and then stops; busy falls after the last write.
- R6: After a run, the bins stay unchanged and nothing is shifted out until a scan request arrives.
- R7: A scan request that arrives while busy is remembered and served once the run ends, with no second request.
- R8: Unload sends every bin in ascending code order. Each bin is BIN_W bits (12 by default), most significant bit first. One bit is sent on scan_out per cycle in SHIFT with scan_tick high, marked by scan_valid; cycles without scan_tick send nothing.
- R9: unload_done rises in the cycle after the last bit of code 2^CODE_W-1. It stays high, with scan_valid low, until the next start.
- R10: A start while busy or during unload is ignored: the run keeps its sample count and the unload completes intact.
- R11: A scan request in IDLE, with no run collected, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start-run command pulse |
| adc_code | input | CODE_W | Conversion result |
| conv_done | input | 1 | Conversion result valid strobe |
| conv_start | output | 1 | Start-conversion pulse to the converter |
| scan_req | input | 1 | Scan-out request pulse |
| scan_tick | input | 1 | Scan clock enable, one bit per high cycle |
| scan_out | output | 1 | Serial histogram bit |
| scan_valid | output | 1 | scan_out carries a bit this cycle |
| busy | output | 1 | High through clear and capture |
| unload_done | output | 1 | Unload finished |

## Verification
The capture path is tried with three code streams.
- A constant mid-scale code with the shortest converter latency fills one bin to its full 2048. This shows that hold-off loses no same-address increments and that the bin width does not overflow.
- A ramp through all codes gives every bin the same count. This exposes address or ordering errors and leftovers from the previous run.
- A pseudo-random stream gives uneven counts.

Unload runs with a steady scan tick and with sparse, irregular ticks, which separates tick-paced shifting from free-running shifting. Start pulses during capture and unload, scan requests in idle, during capture and after a pause, and an unrequested wait in the hold state separate correct sequencing from premature or lost actions.

// File: rtl/hist_pkg.sv
package hist_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_REQ,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_HOLD,
        ST_LOAD,
        ST_FETCH,
        ST_SHIFT,
        ST_DONE
    } hist_state_e;

endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/hist_run_counter.sv
module hist_run_counter #(
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last = (cnt_q == TOP);
endmodule

// File: rtl/hist_shifter.sv
module hist_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              msb,
    output logic              last
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  bcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            sh_q   <= load_data;
            bcnt_q <= CNT_W'(DATA_W - 1);
        end else if (shift) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            if (bcnt_q != '0) begin
                bcnt_q <= bcnt_q - CNT_W'(1);
            end
        end
    end

    assign msb  = sh_q[DATA_W-1];
    assign last = (bcnt_q == '0);
endmodule

// File: rtl/hist_collector.sv
module hist_collector
    import hist_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int NUM_SAMPLES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] adc_code,
    input  logic              conv_done,
    output logic              conv_start,
    input  logic              scan_req,
    input  logic              scan_tick,
    output logic              scan_out,
    output logic              scan_valid,
    output logic              busy,
    output logic              unload_done
);
    localparam int BIN_W = $clog2(NUM_SAMPLES + 1);
    localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

    hist_state_e state_q, state_d;

    logic [CODE_W-1:0] idx_q;
    logic [CODE_W-1:0] code_q;
    logic              pend_q;

    logic              ram_we, ram_re;
    logic [CODE_W-1:0] ram_waddr, ram_raddr;
    logic [BIN_W-1:0]  ram_wdata, ram_rdata;
    logic              cnt_clr, cnt_inc, cnt_last;
    logic              sh_load, sh_shift, sh_msb, sh_last;
    logic              capturing;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CLEAR;
            ST_CLEAR: if (idx_q == TOP_CODE) state_d = ST_REQ;
            ST_REQ:   state_d = ST_WAIT;
            ST_WAIT:  if (conv_done) state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = cnt_last ? ST_HOLD : ST_REQ;
            ST_HOLD: begin
                if (start) begin
                    state_d = ST_CLEAR;
                end else if (pend_q || scan_req) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD:  state_d = ST_FETCH;
            ST_FETCH: state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (scan_tick && sh_last) begin
                    state_d = (idx_q == TOP_CODE) ? ST_DONE : ST_LOAD;
                end
            end
            ST_DONE:  if (start) state_d = ST_CLEAR;
            default:  state_d = ST_IDLE;
        endcase
    end

    // output and control decode
    always_comb begin
        capturing   = (state_q == ST_CLEAR) || (state_q == ST_REQ) ||
                      (state_q == ST_WAIT)  || (state_q == ST_READ) ||
                      (state_q == ST_WRITE);
        busy        = capturing;
        conv_start  = (state_q == ST_REQ);
        scan_valid  = (state_q == ST_SHIFT) && scan_tick;
        scan_out    = sh_msb;
        unload_done = (state_q == ST_DONE);

        ram_we    = (state_q == ST_CLEAR) || (state_q == ST_WRITE);
        ram_waddr = (state_q == ST_CLEAR) ? idx_q : code_q;
        ram_wdata = (state_q == ST_CLEAR) ? '0 : ram_rdata + BIN_W'(1);
        ram_re    = (state_q == ST_READ) || (state_q == ST_LOAD);
        ram_raddr = (state_q == ST_READ) ? code_q : idx_q;

        cnt_clr  = (state_q == ST_CLEAR);
        cnt_inc  = (state_q == ST_WRITE);
        sh_load  = (state_q == ST_FETCH);
        sh_shift = (state_q == ST_SHIFT) && scan_tick;
    end

    // index, code latch and pending scan request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            code_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (state_q != ST_CLEAR && state_d == ST_CLEAR) begin
                idx_q <= '0;
            end else if (state_q == ST_CLEAR) begin
                idx_q <= idx_q + CODE_W'(1);
            end else if (state_q == ST_HOLD && state_d == ST_LOAD) begin
                idx_q <= '0;
            end else if (state_q == ST_SHIFT && scan_tick && sh_last) begin
                idx_q <= idx_q + CODE_W'(1);
            end

            if (state_q == ST_WAIT && conv_done) begin
                code_q <= adc_code;
            end

            if (state_q != ST_CLEAR && state_d == ST_CLEAR) begin
                pend_q <= 1'b0;
            end else if (state_q == ST_HOLD && state_d == ST_LOAD) begin
                pend_q <= 1'b0;
            end else if (scan_req && (capturing || state_q == ST_HOLD)) begin
                pend_q <= 1'b1;
            end
        end
    end

    hist_ram #(.ADDR_W(CODE_W), .DATA_W(BIN_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    hist_run_counter #(.LIMIT(NUM_SAMPLES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .last  (cnt_last)
    );

    hist_shifter #(.DATA_W(BIN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_data (ram_rdata),
        .shift     (sh_shift),
        .msb       (sh_msb),
        .last      (sh_last)
    );
endmodule

// File: rtl/hist_collector_chk.sv
module hist_collector_chk #(
    parameter int CODE_W      = 8,
    parameter int NUM_SAMPLES = 2048
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic conv_done,
    input logic conv_start,
    input logic scan_valid,
    input logic busy,
    input logic unload_done
);
    localparam int BIN_W      = $clog2(NUM_SAMPLES + 1);
    localparam int TOTAL_BITS = (1 << CODE_W) * BIN_W;
    localparam int RC_W       = $clog2(NUM_SAMPLES + 1) + 1;
    localparam int BC_W       = $clog2(TOTAL_BITS + 1) + 1;

    logic            outstanding_q;
    logic [RC_W-1:0] run_cnt_q;
    logic [BC_W-1:0] bit_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
            run_cnt_q     <= '0;
            bit_cnt_q     <= '0;
        end else begin
            if (conv_start) begin
                outstanding_q <= 1'b1;
            end else if (conv_done) begin
                outstanding_q <= 1'b0;
            end
            if (!busy) begin
                run_cnt_q <= '0;
            end else if (conv_start) begin
                run_cnt_q <= run_cnt_q + RC_W'(1);
            end
            if (busy) begin
                bit_cnt_q <= '0;
            end else if (scan_valid) begin
                bit_cnt_q <= bit_cnt_q + BC_W'(1);
            end
        end
    end

    assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !outstanding_q);

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_sample_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (run_cnt_q < RC_W'(NUM_SAMPLES)));

    assert_no_scan_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |-> !busy);

    assert_bit_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |-> (bit_cnt_q < BC_W'(TOTAL_BITS)));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unload_done |-> (!scan_valid && !busy));

    assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind hist_collector hist_collector_chk #(
    .CODE_W      (CODE_W),
    .NUM_SAMPLES (NUM_SAMPLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .conv_done   (conv_done),
    .conv_start  (conv_start),
    .scan_valid  (scan_valid),
    .busy        (busy),
    .unload_done (unload_done)
);

// File: tb/sim_hist_collector.sv
module sim_hist_collector;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 8;
    localparam int NSAMP      = 2048;
    localparam int BIN_W      = 12;
    localparam int NCODES     = 1 << CODE_W;
    localparam int TOTAL_BITS = NCODES * BIN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CODE_W-1:0] adc_code;
    logic conv_done;
    logic conv_start;
    logic scan_req = 1'b0;
    logic scan_tick = 1'b0;
    logic scan_out, scan_valid, busy, unload_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int mode = 0;
    int lat = 0;
    int conv_count = 0;
    int seq_n = 0;
    logic [7:0] lfsr = 8'h5a;
    int exp_hist [NCODES];
    int got_hist [NCODES];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hist_collector #(.CODE_W(CODE_W), .NUM_SAMPLES(NSAMP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_code(adc_code),
        .conv_done(conv_done), .conv_start(conv_start), .scan_req(scan_req),
        .scan_tick(scan_tick), .scan_out(scan_out), .scan_valid(scan_valid),
        .busy(busy), .unload_done(unload_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] next_code();
        logic [7:0] c;
        case (mode)
            0: c = 8'h80;
            1: c = 8'(seq_n % NCODES);
            default: begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                c = lfsr;
            end
        endcase
        seq_n++;
        return c;
    endfunction

    // converter model
    initial begin
        conv_done = 1'b0;
        adc_code = '0;
        forever begin
            @(negedge clk);
            if (rst_n && conv_start) begin
                repeat (lat) @(negedge clk);
                @(negedge clk);
                adc_code = next_code();
                exp_hist[adc_code]++;
                conv_count++;
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    task automatic new_run(input int m, input int l);
        mode = m;
        lat = l;
        conv_count = 0;
        seq_n = 0;
        for (int i = 0; i < NCODES; i++) exp_hist[i] = 0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !conv_start && !scan_valid && !unload_done, "R1",
              "outputs quiet in reset", {busy, conv_start, scan_valid, unload_done}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !conv_start && !scan_valid && !unload_done, "R1",
              "outputs quiet after reset", {busy, conv_start, scan_valid, unload_done}, 0);
    endtask

    task automatic t_idle_scan;
        int seen = 0;
        @(posedge clk); #1 scan_req = 1'b1; scan_tick = 1'b1;
        @(posedge clk); #1 scan_req = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (scan_valid || busy) seen++;
        end
        @(posedge clk); #1 scan_tick = 1'b0;
        check(seen == 0, "R11", "idle scan request produced activity", seen, 0);
    endtask

    // start a run and capture it; optional early scan request and stray start
    task automatic t_capture(input bit early_scan, input bit stray_start);
        int n = 0;
        int guard = 0;
        int scan_seen = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) check(busy == 1'b1, "R2", "busy after start", busy, 1);
        end while (!conv_start && n < 1000);
        check(n == NCODES + 1, "R2", "cycles from start to first conv_start", n, NCODES + 1);
        if (early_scan) begin
            @(posedge clk); #1 scan_req = 1'b1; scan_tick = 1'b1;
            @(posedge clk); #1 scan_req = 1'b0;
        end
        while (busy && guard < 100000) begin
            @(posedge clk);
            #1 start = (stray_start && guard == 3000);
            @(negedge clk);
            if (scan_valid) scan_seen++;
            guard++;
        end
        @(posedge clk); #1 start = 1'b0;
        check(scan_seen == 0, "R7", "bits shifted while busy", scan_seen, 0);
        check(conv_count == NSAMP, "R5", "conversions in run", conv_count, NSAMP);
        if (stray_start)
            check(conv_count == NSAMP, "R10", "stray start kept sample count", conv_count, NSAMP);
    endtask

    task automatic t_hold_quiet;
        int seen = 0;
        int extra = conv_count;
        @(posedge clk); #1 scan_tick = 1'b1;
        repeat (30) begin
            @(negedge clk);
            if (scan_valid || conv_start || busy) seen++;
        end
        check(seen == 0, "R6", "activity in hold without request", seen, 0);
        check(conv_count == extra, "R5", "conversions after run end", conv_count, extra);
    endtask

    // unload and compare; tick_mode 0 steady, 1 every third, 2 irregular
    task automatic t_unload(input bit need_req, input int tick_mode,
                            input bit stray_start, input string req);
        int bits = 0;
        int cyc = 0;
        int acc = 0;
        int bad = 0;
        int bad_code = -1;
        int late = 0;
        for (int i = 0; i < NCODES; i++) got_hist[i] = -1;
        if (need_req) begin
            @(posedge clk); #1 scan_req = 1'b1;
            @(posedge clk); #1 scan_req = 1'b0;
        end
        while (bits < TOTAL_BITS && cyc < 40000) begin
            @(posedge clk);
            #1;
            case (tick_mode)
                0: scan_tick = 1'b1;
                1: scan_tick = (cyc % 3 == 0);
                default: scan_tick = ((cyc % 7) == 1) || ((cyc % 5) == 0);
            endcase
            start = stray_start && (bits == 1000) && (cyc % 2 == 0);
            @(negedge clk);
            if (busy) late++;
            if (scan_valid) begin
                acc = ((acc << 1) | int'(scan_out)) & ((1 << BIN_W) - 1);
                bits++;
                if (bits % BIN_W == 0) got_hist[bits / BIN_W - 1] = acc;
            end
            cyc++;
        end
        @(posedge clk); #1 scan_tick = 1'b1; start = 1'b0;
        check(bits == TOTAL_BITS, "R8", "bits unloaded", bits, TOTAL_BITS);
        for (int i = 0; i < NCODES; i++) begin
            if (got_hist[i] != exp_hist[i]) begin
                bad++;
                if (bad_code < 0) bad_code = i;
            end
        end
        check(bad == 0, req, "mismatching bins", bad, 0);
        if (bad_code >= 0)
            check(1'b0, req, $sformatf("bin %0d value", bad_code),
                  got_hist[bad_code], exp_hist[bad_code]);
        if (stray_start)
            check(late == 0, "R10", "start during unload restarted capture", late, 0);
        @(negedge clk);
        check(unload_done == 1'b1, "R9", "unload_done after last bit", unload_done, 1);
        repeat (5) @(negedge clk);
        check(unload_done && !scan_valid, "R9", "done held and quiet",
              {unload_done, scan_valid}, 2);
        @(posedge clk); #1 scan_tick = 1'b0;
    endtask

    task automatic t_run_const;
        new_run(0, 0);
        t_capture(1'b0, 1'b1);
        t_hold_quiet();
        t_unload(1'b1, 0, 1'b0, "R4");
        check(got_hist[8'h80] == NSAMP, "R3", "same-code back-to-back count",
              got_hist[8'h80], NSAMP);
    endtask

    task automatic t_run_ramp;
        new_run(1, 2);
        t_capture(1'b1, 1'b0);
        t_unload(1'b0, 1, 1'b1, "R7");
        check(got_hist[8'h80] == NSAMP / NCODES, "R2", "previous run cleared",
              got_hist[8'h80], NSAMP / NCODES);
        check(got_hist[0] == 8 && got_hist[NCODES - 1] == 8, "R8", "edge bins in order",
              got_hist[0] + got_hist[NCODES - 1], 16);
    endtask

    task automatic t_run_random;
        new_run(2, 1);
        t_capture(1'b0, 1'b0);
        t_unload(1'b1, 2, 1'b0, "R4");
    endtask

    initial begin
        for (int i = 0; i < NCODES; i++) exp_hist[i] = 0;
        t_reset();
        t_idle_scan();
        t_run_const();
        t_run_ramp();
        t_run_random();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule